// File: doc/BRIEF.md
# Write-Channel Width Splitter (256-bit to two 128-bit ports)

This block sits between a 256-bit AXI4 write master and two 128-bit AXI4 write slaves. Each master burst is forwarded to both slaves. The upper slave receives the upper half of every master data word, and the lower slave receives the lower half. The write address, transfer size and burst length are rewritten for each slave. Every master data beat is turned into a pair of 16-byte slave beats on each port. On each port the first beat of the pair carries that port's half and its strobes, and the second beat is a null beat whose strobes are all zero. The two slave write responses are then merged into one master response.

Only one burst is in flight at a time. Incoming bursts that the block cannot map are rejected: this covers a burst type other than incrementing, a beat size other than 32 bytes, a start address that is not on a 32-byte boundary, or a length that would not fit once doubled. A rejected burst raises a one-cycle error flag. Its data is drained and discarded, and the master receives a slave-error response. Nothing of a rejected burst reaches either slave.

Top module: `wsplit_top`

## Requirements
- R1: For an accepted burst with start address A and length field L, the lower port issues address A and the upper port issues A+0x10. Both ports issue size code 4 and burst code 01 (incrementing), with length field 2*L+1. Slave beats therefore advance in 16-byte steps.
- R2: On each slave port, the address valid stays asserted until that port's own handshake completes; the two ports may complete in different cycles. No slave write beat is presented until both address handshakes have finished.
- R3: The upper port carries master data bits [255:128] and strobes [31:16]. The lower port carries data bits [127:0] and strobes [15:0].
- R4: Each master beat produces exactly two beats on each port. The first beat of the pair carries the port's strobes, and the second beat has all 16 strobe bits at zero.
- R5: A port that has completed the current beat of a pair drops its write valid until the other port completes the same beat. The master write ready is high only in the cycle where the second beat of the pair completes on the last of the two ports.
- R6: Slave WLAST is high only on the second beat of the pair produced from the master beat that carries WLAST.
- R7: The master write response becomes valid only after both slave responses have been taken. Its code is the numerically larger of the two (OKAY=0, EXOKAY=1, SLVERR=2, DECERR=3). Each slave response ready is low once that slave's response has been captured.
- R8: A burst with burst code not 01, size code not 5, address bits [4:0] not zero, or length field above 127 raises the error output in its address handshake cycle. It issues nothing on either slave port. Its write beats are accepted and discarded through WLAST, and the master then gets response code 2 (SLVERR).
- R9: The master address ready is high only when no burst is in progress.
- R10: After reset the master address ready is high, and every valid output and the error output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awvalid | input | 1 | Master address valid |
| m_awready | output | 1 | Master address ready |
| m_awaddr | input | ADDR_W | Master start address |
| m_awlen | input | 8 | Master beats minus one |
| m_awsize | input | 3 | Master beat size code |
| m_awburst | input | 2 | Master burst type |
| m_wvalid | input | 1 | Master data valid |
| m_wready | output | 1 | Master data ready |
| m_wdata | input | M_DATA_W | Master write data |
| m_wstrb | input | M_DATA_W/8 | Master byte strobes |
| m_wlast | input | 1 | Master last beat |
| m_bvalid | output | 1 | Merged response valid |
| m_bready | input | 1 | Merged response ready |
| m_bresp | output | 2 | Merged response code |
| cfg_err | output | 1 | Pulse on a rejected burst |
| u_awvalid | output | 1 | Upper port address valid |
| u_awready | input | 1 | Upper port address ready |
| u_awaddr | output | ADDR_W | Upper port start address |
| u_awlen | output | 8 | Upper port length |
| u_awsize | output | 3 | Upper port size code |
| u_awburst | output | 2 | Upper port burst type |
| u_wvalid | output | 1 | Upper port data valid |
| u_wready | input | 1 | Upper port data ready |
| u_wdata | output | M_DATA_W/2 | Upper port data |
| u_wstrb | output | M_DATA_W/16 | Upper port strobes |
| u_wlast | output | 1 | Upper port last beat |
| u_bvalid | input | 1 | Upper port response valid |
| u_bready | output | 1 | Upper port response ready |
| u_bresp | input | 2 | Upper port response code |
| l_awvalid | output | 1 | Lower port address valid |
| l_awready | input | 1 | Lower port address ready |
| l_awaddr | output | ADDR_W | Lower port start address |
| l_awlen | output | 8 | Lower port length |
| l_awsize | output | 3 | Lower port size code |
| l_awburst | output | 2 | Lower port burst type |
| l_wvalid | output | 1 | Lower port data valid |
| l_wready | input | 1 | Lower port data ready |
| l_wdata | output | M_DATA_W/2 | Lower port data |
| l_wstrb | output | M_DATA_W/16 | Lower port strobes |
| l_wlast | output | 1 | Lower port last beat |
| l_bvalid | input | 1 | Lower port response valid |
| l_bready | output | 1 | Lower port response ready |
| l_bresp | input | 2 | Lower port response code |

## Verification
The critical coincidence is one port completing the second beat of a pair in the same cycle as the master data handshake. On the final pair, that same cycle is also the slave WLAST handshake, which triggers the slave response. Per-port ready patterns with different periods make each port lead and lag in turn, so the lagging port sometimes finishes in a cycle where the leader already waits and sometimes in the same cycle as the leader. The bench model predicts every slave write valid and the master write ready from per-port beat counts each clock, so a master acceptance that comes one cycle early or late is caught in that cycle.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DATA,
        ST_DRAIN,
        ST_RESP,
        ST_LRESP
    } wsplit_state_e;

    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/wsplit_ctrl.sv
module wsplit_ctrl
    import wsplit_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 8,
    parameter int M_SIZE     = 5,
    parameter int HALF_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_awvalid,
    output logic              m_awready,
    input  logic [ADDR_W-1:0] m_awaddr,
    input  logic [LEN_W-1:0]  m_awlen,
    input  logic [2:0]        m_awsize,
    input  logic [1:0]        m_awburst,
    output logic              cfg_err,
    output logic              u_awvalid,
    input  logic              u_awready,
    output logic [ADDR_W-1:0] u_awaddr,
    output logic [LEN_W-1:0]  u_awlen,
    output logic [2:0]        u_awsize,
    output logic [1:0]        u_awburst,
    output logic              l_awvalid,
    input  logic              l_awready,
    output logic [ADDR_W-1:0] l_awaddr,
    output logic [LEN_W-1:0]  l_awlen,
    output logic [2:0]        l_awsize,
    output logic [1:0]        l_awburst,
    output logic              w_en,
    output logic              w_drain,
    input  logic              w_last_acc,
    output logic              b_merge,
    output logic              b_local,
    input  logic              b_done
);

    typedef struct packed {
        wsplit_state_e     st;
        logic              u_sent;
        logic              l_sent;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } ctrl_t;

    ctrl_t c_q, c_d;
    logic  aw_hs, bad, u_hs, l_hs;

    always_comb begin
        c_d       = c_q;
        m_awready = (c_q.st == ST_IDLE);
        aw_hs     = m_awvalid & m_awready;
        bad       = (m_awburst != BURST_INCR) | (m_awsize != 3'(M_SIZE))
                  | (|m_awaddr[M_SIZE-1:0]) | m_awlen[LEN_W-1];
        cfg_err   = aw_hs & bad;

        u_awvalid = (c_q.st == ST_ISSUE) & ~c_q.u_sent;
        l_awvalid = (c_q.st == ST_ISSUE) & ~c_q.l_sent;
        u_hs      = u_awvalid & u_awready;
        l_hs      = l_awvalid & l_awready;
        u_awaddr  = c_q.addr + ADDR_W'(HALF_BYTES);
        l_awaddr  = c_q.addr;
        u_awlen   = {c_q.len[LEN_W-2:0], 1'b1};
        l_awlen   = {c_q.len[LEN_W-2:0], 1'b1};
        u_awsize  = 3'(M_SIZE - 1);
        l_awsize  = 3'(M_SIZE - 1);
        u_awburst = BURST_INCR;
        l_awburst = BURST_INCR;

        w_en      = (c_q.st == ST_DATA);
        w_drain   = (c_q.st == ST_DRAIN);
        b_merge   = (c_q.st == ST_RESP);
        b_local   = (c_q.st == ST_LRESP);

        case (c_q.st)
            ST_IDLE: begin
                if (aw_hs) begin
                    c_d.addr   = m_awaddr;
                    c_d.len    = m_awlen;
                    c_d.u_sent = 1'b0;
                    c_d.l_sent = 1'b0;
                    c_d.st     = bad ? ST_DRAIN : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                c_d.u_sent = c_q.u_sent | u_hs;
                c_d.l_sent = c_q.l_sent | l_hs;
                if (c_d.u_sent & c_d.l_sent) c_d.st = ST_DATA;
            end
            ST_DATA:  if (w_last_acc) c_d.st = ST_RESP;
            ST_DRAIN: if (w_last_acc) c_d.st = ST_LRESP;
            ST_RESP, ST_LRESP: if (b_done) c_d.st = ST_IDLE;
            default:  c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{ST_IDLE, 1'b0, 1'b0, '0, '0};
        else        c_q <= c_d;
    end

    // R2: each slave address request is held until its own handshake
    p_u_aw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        u_awvalid && !u_awready |=> u_awvalid && $stable(u_awaddr));
    p_l_aw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l_awvalid && !l_awready |=> l_awvalid && $stable(l_awaddr));

endmodule

// File: rtl/wsplit_wseq.sv
module wsplit_wseq #(
    parameter int S_DATA_W = 128,
    parameter int S_STRB_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  drain,
    input  logic                  m_wvalid,
    output logic                  m_wready,
    input  logic [2*S_DATA_W-1:0] m_wdata,
    input  logic [2*S_STRB_W-1:0] m_wstrb,
    input  logic                  m_wlast,
    output logic                  u_wvalid,
    input  logic                  u_wready,
    output logic [S_DATA_W-1:0]   u_wdata,
    output logic [S_STRB_W-1:0]   u_wstrb,
    output logic                  u_wlast,
    output logic                  l_wvalid,
    input  logic                  l_wready,
    output logic [S_DATA_W-1:0]   l_wdata,
    output logic [S_STRB_W-1:0]   l_wstrb,
    output logic                  l_wlast
);

    typedef struct packed {
        logic odd;
        logic u_done;
        logic l_done;
    } seq_t;

    seq_t s_q, s_d;
    logic u_fin, l_fin, both;

    always_comb begin
        s_d      = s_q;
        u_wvalid = en & m_wvalid & ~s_q.u_done;
        l_wvalid = en & m_wvalid & ~s_q.l_done;
        u_fin    = s_q.u_done | (u_wvalid & u_wready);
        l_fin    = s_q.l_done | (l_wvalid & l_wready);
        both     = u_fin & l_fin;
        m_wready = drain | (s_q.odd & both);

        if (both) begin
            s_d.u_done = 1'b0;
            s_d.l_done = 1'b0;
            s_d.odd    = ~s_q.odd;
        end else begin
            s_d.u_done = u_fin;
            s_d.l_done = l_fin;
        end

        u_wdata = m_wdata[2*S_DATA_W-1:S_DATA_W];
        l_wdata = m_wdata[S_DATA_W-1:0];
        u_wstrb = s_q.odd ? '0 : m_wstrb[2*S_STRB_W-1:S_STRB_W];
        l_wstrb = s_q.odd ? '0 : m_wstrb[S_STRB_W-1:0];
        u_wlast = s_q.odd & m_wlast;
        l_wlast = s_q.odd & m_wlast;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: a presented slave beat stays until taken
    p_u_w_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        u_wvalid && !u_wready |=> u_wvalid && $stable(u_wstrb) && $stable(u_wlast));
    p_l_w_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        l_wvalid && !l_wready |=> l_wvalid && $stable(l_wstrb) && $stable(l_wlast));

endmodule

// File: rtl/wsplit_bmerge.sv
module wsplit_bmerge
    import wsplit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       merge,
    input  logic       local_err,
    input  logic       u_bvalid,
    output logic       u_bready,
    input  logic [1:0] u_bresp,
    input  logic       l_bvalid,
    output logic       l_bready,
    input  logic [1:0] l_bresp,
    output logic       m_bvalid,
    input  logic       m_bready,
    output logic [1:0] m_bresp,
    output logic       done
);

    typedef struct packed {
        logic       got_u;
        logic       got_l;
        logic [1:0] resp_u;
        logic [1:0] resp_l;
    } bm_t;

    bm_t b_q, b_d;

    always_comb begin
        b_d      = b_q;
        u_bready = merge & ~b_q.got_u;
        l_bready = merge & ~b_q.got_l;
        if (local_err) begin
            m_bvalid = 1'b1;
            m_bresp  = RESP_SLVERR;
        end else begin
            m_bvalid = merge & b_q.got_u & b_q.got_l;
            m_bresp  = (b_q.resp_u > b_q.resp_l) ? b_q.resp_u : b_q.resp_l;
        end
        done = m_bvalid & m_bready;

        if (u_bvalid & u_bready) begin
            b_d.got_u  = 1'b1;
            b_d.resp_u = u_bresp;
        end
        if (l_bvalid & l_bready) begin
            b_d.got_l  = 1'b1;
            b_d.resp_l = l_bresp;
        end
        if (done) begin
            b_d.got_u = 1'b0;
            b_d.got_l = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    // R7: merged response is held stable until taken
    p_bresp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_bvalid && !m_bready |=> m_bvalid && $stable(m_bresp));

endmodule

// File: rtl/wsplit_top.sv
module wsplit_top #(
    parameter int ADDR_W   = 32,
    parameter int M_DATA_W = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  m_awvalid,
    output logic                  m_awready,
    input  logic [ADDR_W-1:0]     m_awaddr,
    input  logic [7:0]            m_awlen,
    input  logic [2:0]            m_awsize,
    input  logic [1:0]            m_awburst,
    input  logic                  m_wvalid,
    output logic                  m_wready,
    input  logic [M_DATA_W-1:0]   m_wdata,
    input  logic [M_DATA_W/8-1:0] m_wstrb,
    input  logic                  m_wlast,
    output logic                  m_bvalid,
    input  logic                  m_bready,
    output logic [1:0]            m_bresp,
    output logic                  cfg_err,
    output logic                  u_awvalid,
    input  logic                  u_awready,
    output logic [ADDR_W-1:0]     u_awaddr,
    output logic [7:0]            u_awlen,
    output logic [2:0]            u_awsize,
    output logic [1:0]            u_awburst,
    output logic                  u_wvalid,
    input  logic                  u_wready,
    output logic [M_DATA_W/2-1:0] u_wdata,
    output logic [M_DATA_W/16-1:0] u_wstrb,
    output logic                  u_wlast,
    input  logic                  u_bvalid,
    output logic                  u_bready,
    input  logic [1:0]            u_bresp,
    output logic                  l_awvalid,
    input  logic                  l_awready,
    output logic [ADDR_W-1:0]     l_awaddr,
    output logic [7:0]            l_awlen,
    output logic [2:0]            l_awsize,
    output logic [1:0]            l_awburst,
    output logic                  l_wvalid,
    input  logic                  l_wready,
    output logic [M_DATA_W/2-1:0] l_wdata,
    output logic [M_DATA_W/16-1:0] l_wstrb,
    output logic                  l_wlast,
    input  logic                  l_bvalid,
    output logic                  l_bready,
    input  logic [1:0]            l_bresp
);

    localparam int S_DATA_W   = M_DATA_W / 2;
    localparam int S_STRB_W   = S_DATA_W / 8;
    localparam int M_SIZE     = $clog2(M_DATA_W / 8);
    localparam int HALF_BYTES = S_STRB_W;

    logic w_en, w_drain, w_last_acc, b_merge, b_local, b_done;

    assign w_last_acc = m_wvalid & m_wready & m_wlast;

    wsplit_ctrl #(
        .ADDR_W(ADDR_W), .LEN_W(8), .M_SIZE(M_SIZE), .HALF_BYTES(HALF_BYTES)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .cfg_err(cfg_err),
        .u_awvalid(u_awvalid), .u_awready(u_awready), .u_awaddr(u_awaddr),
        .u_awlen(u_awlen), .u_awsize(u_awsize), .u_awburst(u_awburst),
        .l_awvalid(l_awvalid), .l_awready(l_awready), .l_awaddr(l_awaddr),
        .l_awlen(l_awlen), .l_awsize(l_awsize), .l_awburst(l_awburst),
        .w_en(w_en), .w_drain(w_drain), .w_last_acc(w_last_acc),
        .b_merge(b_merge), .b_local(b_local), .b_done(b_done)
    );

    wsplit_wseq #(.S_DATA_W(S_DATA_W), .S_STRB_W(S_STRB_W)) i_wseq (
        .clk(clk), .rst_n(rst_n), .en(w_en), .drain(w_drain),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .u_wvalid(u_wvalid), .u_wready(u_wready), .u_wdata(u_wdata),
        .u_wstrb(u_wstrb), .u_wlast(u_wlast),
        .l_wvalid(l_wvalid), .l_wready(l_wready), .l_wdata(l_wdata),
        .l_wstrb(l_wstrb), .l_wlast(l_wlast)
    );

    wsplit_bmerge i_bmerge (
        .clk(clk), .rst_n(rst_n), .merge(b_merge), .local_err(b_local),
        .u_bvalid(u_bvalid), .u_bready(u_bready), .u_bresp(u_bresp),
        .l_bvalid(l_bvalid), .l_bready(l_bready), .l_bresp(l_bresp),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .done(b_done)
    );

    // R8: a rejected burst never drives data toward either slave
    p_drain_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        w_drain |-> !u_wvalid && !l_wvalid);

endmodule

// File: tb/test_wsplit_top.sv
module test_wsplit_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_awvalid = 0, m_awready;
    logic [31:0]  m_awaddr = 0;
    logic [7:0]   m_awlen = 0;
    logic [2:0]   m_awsize = 0;
    logic [1:0]   m_awburst = 0;
    logic         m_wvalid = 0, m_wready;
    logic [255:0] m_wdata = 0;
    logic [31:0]  m_wstrb = 0;
    logic         m_wlast = 0;
    logic         m_bvalid, m_bready = 0;
    logic [1:0]   m_bresp;
    logic         cfg_err;
    logic         u_awvalid, u_awready = 0, l_awvalid, l_awready = 0;
    logic [31:0]  u_awaddr, l_awaddr;
    logic [7:0]   u_awlen, l_awlen;
    logic [2:0]   u_awsize, l_awsize;
    logic [1:0]   u_awburst, l_awburst;
    logic         u_wvalid, u_wready = 0, u_wlast, l_wvalid, l_wready = 0, l_wlast;
    logic [127:0] u_wdata, l_wdata;
    logic [15:0]  u_wstrb, l_wstrb;
    logic         u_bvalid = 0, u_bready, l_bvalid = 0, l_bready;
    logic [1:0]   u_bresp = 0, l_bresp = 0;

    always #4 clk = ~clk;

    wsplit_top i_wsplit_top (.*);

    int nvec = 0;
    int nfail = 0;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    localparam int NB = 9;
    logic [31:0] t_addr [NB];
    logic [7:0]  t_len  [NB];
    logic [2:0]  t_size [NB];
    logic [1:0]  t_burst[NB];
    logic [1:0]  t_ur   [NB];
    logic [1:0]  t_lr   [NB];
    int          t_mode [NB];

    function automatic logic [255:0] mk_data(int b, int k);
        logic [31:0] hi, lo;
        hi = 32'(b * 4096 + k * 2 + 1);
        lo = 32'(b * 4096 + k * 2);
        return {hi, hi, hi, hi, lo, lo, lo, lo};
    endfunction

    function automatic logic [31:0] mk_strb(int b, int k);
        return 32'((b * 7 + k * 13 + 5) * 32'h0101_0101) ^ 32'hA5A5_3C3C;
    endfunction

    function automatic bit is_bad(int b);
        return (t_burst[b] != 2'b01) || (t_size[b] != 3'd5) ||
               (t_addr[b][4:0] != 5'd0) || (t_len[b] > 8'd127);
    endfunction

    initial begin
        // model and driver state
        int  ph, ku, kl, bi, wi, cyc, mode;
        bit  su, sl, gu, gl, d_aw, w_on, d_wv, ub_pend, lb_pend;
        bit  uhs, lhs, exp_bv, exp_wr;
        logic [31:0] s;

        t_addr[0] = 32'h0;    t_len[0] = 3;   t_size[0] = 5; t_burst[0] = 1; t_ur[0] = 0; t_lr[0] = 0; t_mode[0] = 0;
        t_addr[1] = 32'h1000; t_len[1] = 0;   t_size[1] = 5; t_burst[1] = 1; t_ur[1] = 0; t_lr[1] = 2; t_mode[1] = 1;
        t_addr[2] = 32'h40;   t_len[2] = 5;   t_size[2] = 5; t_burst[2] = 1; t_ur[2] = 3; t_lr[2] = 2; t_mode[2] = 1;
        t_addr[3] = 32'h8;    t_len[3] = 1;   t_size[3] = 5; t_burst[3] = 1; t_ur[3] = 0; t_lr[3] = 0; t_mode[3] = 1;
        t_addr[4] = 32'h20;   t_len[4] = 0;   t_size[4] = 4; t_burst[4] = 1; t_ur[4] = 0; t_lr[4] = 0; t_mode[4] = 0;
        t_addr[5] = 32'h60;   t_len[5] = 2;   t_size[5] = 5; t_burst[5] = 2; t_ur[5] = 0; t_lr[5] = 0; t_mode[5] = 0;
        t_addr[6] = 32'h80;   t_len[6] = 200; t_size[6] = 5; t_burst[6] = 1; t_ur[6] = 0; t_lr[6] = 0; t_mode[6] = 1;
        t_addr[7] = 32'hFFE0; t_len[7] = 127; t_size[7] = 5; t_burst[7] = 1; t_ur[7] = 1; t_lr[7] = 0; t_mode[7] = 1;
        t_addr[8] = 32'h200;  t_len[8] = 1;   t_size[8] = 5; t_burst[8] = 1; t_ur[8] = 2; t_lr[8] = 3; t_mode[8] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R10 awready after reset", m_awready, 1);
        chk("R10 u_awvalid after reset", u_awvalid, 0);
        chk("R10 l_awvalid after reset", l_awvalid, 0);
        chk("R10 u_wvalid after reset", u_wvalid, 0);
        chk("R10 l_wvalid after reset", l_wvalid, 0);
        chk("R10 m_bvalid after reset", m_bvalid, 0);
        chk("R10 cfg_err after reset", cfg_err, 0);

        ph = 0; ku = 0; kl = 0; bi = 0; wi = 0; cyc = 0;
        su = 0; sl = 0; gu = 0; gl = 0; d_aw = 1; w_on = 0; d_wv = 0;
        ub_pend = 0; lb_pend = 0;

        while (bi < NB) begin
            @(negedge clk);
            cyc++;
            if (cyc > 60000) begin
                nfail++;
                $display("FAIL watchdog actual=%0d expected=<60000", cyc);
                break;
            end
            mode = t_mode[bi];
            // drive inputs
            m_awvalid = d_aw;
            m_awaddr  = t_addr[bi];
            m_awlen   = t_len[bi];
            m_awsize  = t_size[bi];
            m_awburst = t_burst[bi];
            m_wvalid  = d_wv;
            m_wdata   = mk_data(bi, wi);
            m_wstrb   = mk_strb(bi, wi);
            m_wlast   = (wi == int'(t_len[bi]));
            u_awready = (mode == 0) ? 1'b1 : (cyc % 2 == 0);
            l_awready = (mode == 0) ? 1'b1 : (cyc % 3 == 0);
            u_wready  = (mode == 0) ? 1'b1 : (cyc % 3 != 1);
            l_wready  = (mode == 0) ? 1'b1 : (cyc % 4 != 0);
            u_bvalid  = ub_pend;
            l_bvalid  = lb_pend;
            u_bresp   = t_ur[bi];
            l_bresp   = t_lr[bi];
            m_bready  = (mode == 0) ? 1'b1 : (cyc % 2 == 1);
            #1;

            // expected outputs
            chk("R9 m_awready", m_awready, ph == 0);
            chk("R8 cfg_err", cfg_err, (ph == 0) && m_awvalid && is_bad(bi));
            chk("R2 u_awvalid", u_awvalid, (ph == 1) && !su);
            chk("R2 l_awvalid", l_awvalid, (ph == 1) && !sl);
            if (u_awvalid && u_awready) begin
                chk("R1 upper addr", u_awaddr, t_addr[bi] + 32'h10);
                chk("R1 upper len", u_awlen, 2 * t_len[bi] + 1);
                chk("R1 upper size", u_awsize, 4);
                chk("R1 upper burst", u_awburst, 1);
            end
            if (l_awvalid && l_awready) begin
                chk("R1 lower addr", l_awaddr, t_addr[bi]);
                chk("R1 lower len", l_awlen, 2 * t_len[bi] + 1);
                chk("R1 lower size", l_awsize, 4);
                chk("R1 lower burst", l_awburst, 1);
            end
            chk("R5 u_wvalid", u_wvalid, (ph == 2) && m_wvalid && (ku <= kl));
            chk("R5 l_wvalid", l_wvalid, (ph == 2) && m_wvalid && (kl <= ku));
            uhs = u_wvalid && u_wready;
            lhs = l_wvalid && l_wready;
            if (uhs) begin
                s = mk_strb(bi, wi);
                chk("R4 upper strobes", u_wstrb, (ku == 0) ? s[31:16] : 16'h0);
                chk("R6 upper wlast", u_wlast, (ku == 1) && m_wlast);
                if (ku == 0) chk("R3 upper data", u_wdata, m_wdata[255:128]);
            end
            if (lhs) begin
                s = mk_strb(bi, wi);
                chk("R4 lower strobes", l_wstrb, (kl == 0) ? s[15:0] : 16'h0);
                chk("R6 lower wlast", l_wlast, (kl == 1) && m_wlast);
                if (kl == 0) chk("R3 lower data", l_wdata, m_wdata[127:0]);
            end
            exp_wr = (ph == 3) ||
                     ((ph == 2) && m_wvalid && (ku + int'(uhs) == 2) && (kl + int'(lhs) == 2));
            chk("R5 m_wready", m_wready, exp_wr);
            chk("R7 u_bready", u_bready, (ph == 4) && !gu);
            chk("R7 l_bready", l_bready, (ph == 4) && !gl);
            exp_bv = ((ph == 4) && gu && gl) || (ph == 5);
            chk("R7 m_bvalid", m_bvalid, exp_bv);
            if (exp_bv && ph == 5) chk("R8 local resp", m_bresp, 2);
            if (exp_bv && ph == 4)
                chk("R7 merged resp", m_bresp, (t_ur[bi] > t_lr[bi]) ? t_ur[bi] : t_lr[bi]);

            // slave response sources
            if (uhs && u_wlast) ub_pend = 1;
            if (lhs && l_wlast) lb_pend = 1;
            if (u_bvalid && u_bready) ub_pend = 0;
            if (l_bvalid && l_bready) lb_pend = 0;

            // model update for the coming edge
            case (ph)
                0: if (m_awvalid && m_awready) begin
                       ph = is_bad(bi) ? 3 : 1;
                       su = 0; sl = 0;
                   end
                1: begin
                       if (u_awvalid && u_awready) su = 1;
                       if (l_awvalid && l_awready) sl = 1;
                       if (su && sl) begin ph = 2; ku = 0; kl = 0; end
                   end
                2: begin
                       ku += int'(uhs);
                       kl += int'(lhs);
                       if (ku == 2 && kl == 2) begin ku = 0; kl = 0; end
                       if (m_wvalid && m_wready && m_wlast) begin ph = 4; gu = 0; gl = 0; end
                   end
                3: if (m_wvalid && m_wready && m_wlast) ph = 5;
                4: begin
                       if (u_bvalid && u_bready) gu = 1;
                       if (l_bvalid && l_bready) gl = 1;
                   end
                default: ;
            endcase

            // master driver update
            if (m_awvalid && m_awready) begin d_aw = 0; w_on = 1; wi = 0; end
            if (m_wvalid && m_wready) begin
                if (m_wlast) w_on = 0;
                else wi++;
                d_wv = 0;
            end
            if (!d_wv) d_wv = w_on && ((mode == 0) || (cyc % 5 != 0));
            if (m_bvalid && m_bready) begin
                ph = 0; gu = 0; gl = 0;
                bi++;
                d_aw = 1; w_on = 0; d_wv = 0; wi = 0;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule